// File: doc/BRIEF.md
# Host Command Parser and Queue

This block sits between a host's 8-bit parallel write port and a bus-master engine. The host writes a byte by lowering a chip-select and pulsing an active-low write strobe. The block brings both strobes into the local clock domain and captures one byte on each completed write. It then works out whether that byte starts a new command or belongs to the trailing data of the command before it.

Accepted bytes go into a command/data queue, 80 entries deep by default. Each entry is tagged as an opcode or as payload, and the entry at the head carries a decoded command class. The engine drains the queue one entry per `pop_i` pulse.

A few commands take effect at once, in addition to being queued:
- rate selection, configuration and slave-address commands update their settings outputs on receipt;
- the flush opcode is never queued: it empties the queue and signals a bus-release request.

The queue fill is reported as a coarse 2-bit band. A write that finds the queue full is dropped and raises an overflow pulse, so that downstream logic can report a full buffer to the host.

Top module: `hostcmd_queue`

## Requirements
- R1: A byte is captured once for each rising edge of `host_wr_n_i` seen while `host_cs_n_i` is low. A strobe pulse with chip-select high has no effect. Data and chip-select must be stable for at least SYNC_STAGES+1 clocks before the strobe rises.
- R2: A byte is an opcode only when no payload is outstanding. Opcodes 0x10–0x1F are followed by (bits 3:0 + 1) payload bytes. Those bytes are queued with `q_is_op_o`=0, and opcodes are queued with `q_is_op_o`=1.
- R3: Opcodes 0x20–0x3F (master receive, count in bits 3:0, last-byte acknowledge control in bit 4) take no payload. The next byte is an opcode.
- R4: Byte 0x00 in opcode position is not queued. It empties the queue in the clock it is taken and pulses `flush_o` for one clock. Byte 0x00 in payload position is queued as data.
- R5: `irq_hold_o` is high from acceptance of a master-transmit opcode until its last payload byte is accepted, and low otherwise.
- R6: Accepted bytes leave the queue in write order. The queue holds DEPTH (80) entries.
- R7: `fill_code_o` is 0 when at least 40 entries are free, 1 when 20–39 are free, 2 when 1–19 are free, and 3 when the queue is full.
- R8: A non-flush write that arrives while the queue is full is discarded. It pulses `overflow_o` for one clock and leaves the queue contents and framing state unchanged.
- R9: Opcodes 0x04–0x07 set `rate_o` to bits 1:0 (0 = 100 kHz, 1 = 400 kHz, 2 = 1 MHz, 3 = reserved). `rate_o` changes only after a captured write.
- R10: Opcodes 0x40–0x7F load `cfg_o` from bits 4:0, where bit 3 enables the slave function. Opcodes 0x80–0xFF load `slave_addr_o` from bits 6:0.
- R11: For an opcode at the head, `q_class_o` gives its class. The codes are 2 = START (0x02), 3 = STOP (0x03), 4 = rate, 5 = status (0x08–0x0F, bit 0 requests a utilization count), 6 = master transmit, 7 = master receive, 8 = configure, 9 = slave address and 10 = reserved (0x01). Payload entries and an empty queue show 0.
- R12: After reset the queue is empty, the fill code is 0, no payload is outstanding, and `rate_o`, `cfg_o` and `slave_addr_o` are all zero (100 kHz, slave disabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_d_i | input | 8 | Host write data |
| host_cs_n_i | input | 1 | Host chip select, active low, asynchronous |
| host_wr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| pop_i | input | 1 | Remove the head entry |
| q_valid_o | output | 1 | Queue holds at least one entry |
| q_byte_o | output | 8 | Head entry byte |
| q_is_op_o | output | 1 | Head entry is an opcode |
| q_class_o | output | 4 | Class of the head opcode |
| fill_code_o | output | 2 | Fill band |
| overflow_o | output | 1 | One-clock pulse for a dropped write |
| flush_o | output | 1 | One-clock pulse: flush taken, release bus |
| irq_hold_o | output | 1 | Master-transmit payload still outstanding |
| rate_o | output | 2 | Selected bus clock rate |
| cfg_o | output | 5 | Configuration bits |
| slave_addr_o | output | 7 | Own 7-bit slave address |

## Verification
The bench targets the places where framing can slip.

A zero byte inside a transmit payload must be queued as data. A design that flushed on it would empty the queue and pulse `flush_o`.

A master-receive opcode must not swallow the next byte as payload. A write dropped while the queue is full must not advance the payload count. Either mistake would leave `irq_hold_o` wrong and shift every later tag.

The fill bands are stepped entry by entry through the 40/39, 20/19 and 1/0 free boundaries, where an off-by-one comparison shows up as a wrong code.

Random command streams mixed with random pops catch order or tag corruption across pointer wrap.

// File: rtl/hcq_pkg.sv
package hcq_pkg;

   typedef enum logic [3:0] {
      CL_DATA   = 4'd0,
      CL_FLUSH  = 4'd1,
      CL_START  = 4'd2,
      CL_STOP   = 4'd3,
      CL_RATE   = 4'd4,
      CL_STATUS = 4'd5,
      CL_MXMIT  = 4'd6,
      CL_MRECV  = 4'd7,
      CL_CONFIG = 4'd8,
      CL_SLADDR = 4'd9,
      CL_RSVD   = 4'd10
   } op_class_e;

   // Highest set bit of an opcode selects its class.
   function automatic op_class_e classify(input logic [7:0] b);
      op_class_e c;
      if (b[7])      c = CL_SLADDR;
      else if (b[6]) c = CL_CONFIG;
      else if (b[5]) c = CL_MRECV;
      else if (b[4]) c = CL_MXMIT;
      else if (b[3]) c = CL_STATUS;
      else if (b[2]) c = CL_RATE;
      else begin
         case (b[1:0])
            2'd0:    c = CL_FLUSH;
            2'd1:    c = CL_RSVD;
            2'd2:    c = CL_START;
            default: c = CL_STOP;
         endcase
      end
      return c;
   endfunction

endpackage

// File: rtl/hcq_wr_sync.sv
module hcq_wr_sync #(
   parameter int SYNC_STAGES = 2,
   parameter int DW          = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] data_i,
   input  logic          cs_n_i,
   input  logic          wr_n_i,
   output logic          evt_o,
   output logic [DW-1:0] byte_o
);

   logic [SYNC_STAGES-1:0] wr_sh;
   logic [SYNC_STAGES-1:0] cs_sh;
   logic [DW-1:0]          dat_sh [SYNC_STAGES];
   logic                   wr_d;
   logic                   cs_d;
   logic [DW-1:0]          dat_d;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_sh[0]  <= 1'b1;
               cs_sh[0]  <= 1'b1;
               dat_sh[0] <= '0;
            end else begin
               wr_sh[0]  <= wr_n_i;
               cs_sh[0]  <= cs_n_i;
               dat_sh[0] <= data_i;
            end
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_sh[i]  <= 1'b1;
               cs_sh[i]  <= 1'b1;
               dat_sh[i] <= '0;
            end else begin
               wr_sh[i]  <= wr_sh[i-1];
               cs_sh[i]  <= cs_sh[i-1];
               dat_sh[i] <= dat_sh[i-1];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_d  <= 1'b1;
         cs_d  <= 1'b1;
         dat_d <= '0;
      end else begin
         wr_d  <= wr_sh[SYNC_STAGES-1];
         cs_d  <= cs_sh[SYNC_STAGES-1];
         dat_d <= dat_sh[SYNC_STAGES-1];
      end
   end

   // Strobe returns high while the aligned chip select is still low.
   assign evt_o  = wr_sh[SYNC_STAGES-1] & ~wr_d & ~cs_d;
   assign byte_o = dat_d;

endmodule

// File: rtl/hcq_framer.sv
module hcq_framer
   import hcq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       evt_i,
   input  logic [7:0] byte_i,
   input  logic       full_i,
   output logic       push_o,
   output logic       push_op_o,
   output logic       flush_o,
   output logic       ovf_o,
   output logic       hold_o,
   output logic [1:0] rate_o,
   output logic [4:0] cfg_o,
   output logic [6:0] saddr_o
);

   logic [4:0] pay_left;
   logic       at_op;
   op_class_e  cls;

   assign at_op     = (pay_left == 5'd0);
   assign cls       = classify(byte_i);
   assign flush_o   = evt_i & at_op & (cls == CL_FLUSH);
   assign push_o    = evt_i & ~flush_o & ~full_i;
   assign ovf_o     = evt_i & ~flush_o & full_i;
   assign push_op_o = at_op;
   assign hold_o    = ~at_op;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pay_left <= '0;
         rate_o   <= '0;
         cfg_o    <= '0;
         saddr_o  <= '0;
      end else if (push_o) begin
         if (at_op) begin
            case (cls)
               CL_MXMIT:  pay_left <= {1'b0, byte_i[3:0]} + 5'd1;
               CL_RATE:   rate_o   <= byte_i[1:0];
               CL_CONFIG: cfg_o    <= byte_i[4:0];
               CL_SLADDR: saddr_o  <= byte_i[6:0];
               default:   ;
            endcase
         end else begin
            pay_left <= pay_left - 5'd1;
         end
      end
   end

endmodule

// File: rtl/hcq_fifo.sv
module hcq_fifo #(
   parameter int DEPTH   = 80,
   parameter int DW      = 8,
   parameter int BAND_HI = 40,
   parameter int BAND_LO = 20
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          push_i,
   input  logic          push_op_i,
   input  logic [DW-1:0] din_i,
   input  logic          pop_i,
   output logic          valid_o,
   output logic [DW-1:0] dout_o,
   output logic          dout_op_o,
   output logic          full_o,
   output logic [1:0]    fill_code_o
);

   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [DW:0]   mem [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;
   logic [CW-1:0] count;
   logic [CW-1:0] free;
   logic          do_pop;

   function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   assign do_pop  = pop_i & valid_o;
   assign valid_o = (count != '0);
   assign full_o  = (count == CW'(DEPTH));
   assign free    = CW'(DEPTH) - count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr_i) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_i) wr_ptr <= nxt(wr_ptr);
         if (do_pop) rd_ptr <= nxt(rd_ptr);
         count <= count + CW'(push_i) - CW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push_i && !clr_i) mem[wr_ptr] <= {push_op_i, din_i};
   end

   assign dout_o    = valid_o ? mem[rd_ptr][DW-1:0] : '0;
   assign dout_op_o = valid_o & mem[rd_ptr][DW];

   always_comb begin
      if (free >= CW'(BAND_HI))      fill_code_o = 2'd0;
      else if (free >= CW'(BAND_LO)) fill_code_o = 2'd1;
      else if (free != '0)           fill_code_o = 2'd2;
      else                           fill_code_o = 2'd3;
   end

endmodule

// File: rtl/hostcmd_queue.sv
module hostcmd_queue
   import hcq_pkg::*;
#(
   parameter int DEPTH       = 80,
   parameter int BAND_HI     = 40,
   parameter int BAND_LO     = 20,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] host_d_i,
   input  logic       host_cs_n_i,
   input  logic       host_wr_n_i,
   input  logic       pop_i,
   output logic       q_valid_o,
   output logic [7:0] q_byte_o,
   output logic       q_is_op_o,
   output logic [3:0] q_class_o,
   output logic [1:0] fill_code_o,
   output logic       overflow_o,
   output logic       flush_o,
   output logic       irq_hold_o,
   output logic [1:0] rate_o,
   output logic [4:0] cfg_o,
   output logic [6:0] slave_addr_o
);

   if (SYNC_STAGES < 1 || BAND_LO < 1 || BAND_LO >= BAND_HI || BAND_HI > DEPTH) begin : g_bad_cfg
      $error("hostcmd_queue: inconsistent DEPTH/BAND/SYNC parameters");
   end

   logic       wr_evt;
   logic [7:0] wr_byte;
   logic       push;
   logic       push_op;
   logic       flush_now;
   logic       ovf_now;
   logic       q_full;

   hcq_wr_sync #(.SYNC_STAGES(SYNC_STAGES), .DW(8)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .data_i (host_d_i),
      .cs_n_i (host_cs_n_i),
      .wr_n_i (host_wr_n_i),
      .evt_o  (wr_evt),
      .byte_o (wr_byte)
   );

   hcq_framer u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .evt_i     (wr_evt),
      .byte_i    (wr_byte),
      .full_i    (q_full),
      .push_o    (push),
      .push_op_o (push_op),
      .flush_o   (flush_now),
      .ovf_o     (ovf_now),
      .hold_o    (irq_hold_o),
      .rate_o    (rate_o),
      .cfg_o     (cfg_o),
      .saddr_o   (slave_addr_o)
   );

   hcq_fifo #(.DEPTH(DEPTH), .DW(8), .BAND_HI(BAND_HI), .BAND_LO(BAND_LO)) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (flush_now),
      .push_i      (push),
      .push_op_i   (push_op),
      .din_i       (wr_byte),
      .pop_i       (pop_i),
      .valid_o     (q_valid_o),
      .dout_o      (q_byte_o),
      .dout_op_o   (q_is_op_o),
      .full_o      (q_full),
      .fill_code_o (fill_code_o)
   );

   assign q_class_o = q_is_op_o ? classify(q_byte_o) : CL_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         overflow_o <= 1'b0;
         flush_o    <= 1'b0;
      end else begin
         overflow_o <= ovf_now;
         flush_o    <= flush_now;
      end
   end

endmodule

// File: rtl/hcq_checker.sv
module hcq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_evt,
   input logic       overflow_o,
   input logic       flush_o,
   input logic       q_valid_o,
   input logic [1:0] fill_code_o,
   input logic       irq_hold_o,
   input logic [1:0] rate_o
);

   AST_OVF_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |-> $past(fill_code_o) == 2'd3);                          // R8
   AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow_o |=> !overflow_o);                                          // R8
   AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !q_valid_o);                                              // R4
   AST_FLUSH_AT_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |-> !irq_hold_o);                                             // R5
   AST_EMPTY_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      !q_valid_o |-> fill_code_o == 2'd0);                                  // R7
   AST_FULL_BAND: assert property (@(posedge clk) disable iff (!rst_n)
      fill_code_o == 2'd3 |-> q_valid_o);                                   // R7
   AST_RATE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_evt) |-> $stable(rate_o));                                  // R9

endmodule

bind hostcmd_queue hcq_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_evt      (wr_evt),
   .overflow_o  (overflow_o),
   .flush_o     (flush_o),
   .q_valid_o   (q_valid_o),
   .fill_code_o (fill_code_o),
   .irq_hold_o  (irq_hold_o),
   .rate_o      (rate_o)
);

// File: tb/hostcmd_queue_tb.sv
module hostcmd_queue_tb;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] d;
   logic       cs_n, wr_n, pop;
   logic       q_valid, q_is_op, overflow, flush, hold;
   logic [7:0] q_byte;
   logic [3:0] q_class;
   logic [1:0] fill, rate;
   logic [4:0] cfg;
   logic [6:0] saddr;

   always #5 clk = ~clk;

   hostcmd_queue u_dut (
      .clk(clk), .rst_n(rst_n), .host_d_i(d), .host_cs_n_i(cs_n), .host_wr_n_i(wr_n),
      .pop_i(pop), .q_valid_o(q_valid), .q_byte_o(q_byte), .q_is_op_o(q_is_op),
      .q_class_o(q_class), .fill_code_o(fill), .overflow_o(overflow), .flush_o(flush),
      .irq_hold_o(hold), .rate_o(rate), .cfg_o(cfg), .slave_addr_o(saddr)
   );

   int checks = 0, fails = 0;
   int ovf_seen = 0, flush_seen = 0, exp_ovf = 0, exp_flush = 0;
   logic [8:0] mq[$];
   int m_pay = 0;
   logic [1:0] m_rate = 2'd0;
   logic [4:0] m_cfg = 5'd0;
   logic [6:0] m_addr = 7'd0;

   always @(posedge clk) if (rst_n) begin
      if (overflow) ovf_seen++;
      if (flush) flush_seen++;
   end

   function automatic int exp_class(input logic [7:0] b);
      if (b >= 8'h80) return 9;
      if (b >= 8'h40) return 8;
      if (b >= 8'h20) return 7;
      if (b >= 8'h10) return 6;
      if (b >= 8'h08) return 5;
      if (b >= 8'h04) return 4;
      if (b == 8'h01) return 10;
      return int'(b);
   endfunction

   function automatic int exp_code(input int used);
      int fr = 80 - used;
      if (fr >= 40) return 0;
      if (fr >= 20) return 1;
      if (fr >= 1) return 2;
      return 3;
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic host_wr(input logic [7:0] b, input bit sel = 1'b1);
      @(negedge clk);
      d = b; cs_n = !sel; wr_n = 1'b0;
      repeat (4) @(negedge clk);
      wr_n = 1'b1;
      repeat (2) @(negedge clk);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      if (sel) begin
         if (m_pay == 0 && b == 8'h00) begin
            mq.delete(); exp_flush++;
         end else if (mq.size() == 80) begin
            exp_ovf++;
         end else if (m_pay == 0) begin
            mq.push_back({1'b1, b});
            if (b[7:4] == 4'h1) m_pay = int'(b[3:0]) + 1;
            if (b[7:2] == 6'h01) m_rate = b[1:0];
            if (b[7:6] == 2'b01) m_cfg = b[4:0];
            if (b[7]) m_addr = b[6:0];
         end else begin
            mq.push_back({1'b0, b});
            m_pay--;
         end
      end
   endtask

   task automatic check_all();
      chk("R6 valid", int'(q_valid), int'(mq.size() != 0));
      if (mq.size() != 0) begin
         chk("R6 head byte", int'(q_byte), int'(mq[0][7:0]));
         chk("R2 head tag", int'(q_is_op), int'(mq[0][8]));
         chk("R11 head class", int'(q_class), mq[0][8] ? exp_class(mq[0][7:0]) : 0);
      end
      chk("R7 fill code", int'(fill), exp_code(mq.size()));
      chk("R5 hold", int'(hold), int'(m_pay != 0));
      chk("R9 rate", int'(rate), int'(m_rate));
      chk("R10 cfg", int'(cfg), int'(m_cfg));
      chk("R10 addr", int'(saddr), int'(m_addr));
      chk("R8 overflow count", ovf_seen, exp_ovf);
      chk("R4 flush count", flush_seen, exp_flush);
   endtask

   task automatic do_pop();
      @(negedge clk) pop = 1'b1;
      @(negedge clk) pop = 1'b0;
      void'(mq.pop_front());
   endtask

   task automatic drain();
      while (mq.size() != 0) begin
         check_all();
         do_pop();
      end
      chk("R6 drained", int'(q_valid), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; d = 8'h00; cs_n = 1'b1; wr_n = 1'b1; pop = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R12 reset state
      chk("R12 empty", int'(q_valid), 0);
      chk("R12 fill", int'(fill), 0);
      chk("R12 rate", int'(rate), 0);
      chk("R12 cfg", int'(cfg), 0);
      chk("R12 addr", int'(saddr), 0);
      chk("R12 hold", int'(hold), 0);

      // R1: strobe with chip select high is ignored
      host_wr(8'h02, 1'b0);
      chk("R1 deselected write", int'(q_valid), 0);
      host_wr(8'h02);
      chk("R1 selected write", int'(q_valid), 1);
      drain();

      // R2/R5/R4: transmit with a zero byte in its payload
      host_wr(8'h12);
      chk("R5 hold after opcode", int'(hold), 1);
      host_wr(8'h00);
      chk("R4 zero payload kept", flush_seen, 0);
      host_wr(8'hAA);
      chk("R5 hold mid payload", int'(hold), 1);
      host_wr(8'h55);
      chk("R5 hold released", int'(hold), 0);
      // R3: receive opcode takes no payload
      host_wr(8'h3F);
      chk("R3 no hold", int'(hold), 0);
      host_wr(8'h02);
      check_all();
      drain();

      // R9/R10 settings
      host_wr(8'h06);
      host_wr(8'h5B);
      host_wr(8'hA5);
      chk("R9 rate 1MHz", int'(rate), 2);
      chk("R10 cfg bits", int'(cfg), 5'h1B);
      chk("R10 slave addr", int'(saddr), 7'h25);
      check_all();

      // R4 flush at opcode position
      host_wr(8'h03);
      host_wr(8'h00);
      chk("R4 flushed", int'(q_valid), 0);
      chk("R4 flush pulse", flush_seen, 1);
      check_all();

      // Random command streams with pops
      void'($urandom(32'd4711));
      for (int n = 0; n < 250; n++) begin
         int k = $urandom_range(0, 19);
         logic [7:0] b = 8'($urandom);
         if (k == 0) b = 8'h00;
         else if (k == 1) b = 8'h01;
         else if (b == 8'h00) b = 8'h02;
         host_wr(b);
         check_all();
         while (m_pay > 0) begin
            host_wr(8'($urandom));
            check_all();
         end
         for (int p = $urandom_range(0, 2); p > 0 && mq.size() != 0; p--) do_pop();
         while (mq.size() > 50) do_pop();
         check_all();
      end

      // R7 fill bands
      host_wr(8'h00);
      for (int i = 1; i <= 80; i++) begin
         host_wr(8'h02);
         chk("R7 band", int'(fill), exp_code(i));
      end
      check_all();

      // R8 overflow: dropped bytes leave contents and framing alone
      host_wr(8'h03);
      chk("R8 overflow pulse", ovf_seen, 1);
      chk("R8 still full", int'(fill), 3);
      host_wr(8'h1F);
      chk("R8 framing unchanged", int'(hold), 0);
      chk("R8 second overflow", ovf_seen, 2);
      do_pop();
      host_wr(8'h03);
      chk("R8 accepted after pop", ovf_seen, 2);
      check_all();
      drain();

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule